// File: doc/BRIEF.md
# DRAM Row/Column Address Sequencer

This block sits between the system bus address decoder and a separate DRAM controller. When the bus master that owns the bus presents an access whose byte address falls in the DRAM window, the sequencer starts a transaction. It raises a request to the controller and places the row part of the halfword address on a shared multiplexed address bus. It then waits for the controller's column-enable strobe before it switches that bus to the column part. How the address splits into row and column comes from a two-bit DRAM size selector, which chooses between 8 and 11 column bits.

The master is held off with a wait output while the transaction is open. Completion is signalled by the controller's ready input. In burst mode the request stays asserted across several ready pulses, and the column advances by one halfword on each of them without a new row phase. The burst is cut off after a parameterised number of beats. The burst indication seen by the controller is the live burst request of the current bus owner.

Top module: `dram_addr_seq`

## Requirements
- R1: A transaction is accepted only when `bus_valid` is high, the sequencer is idle, and `bus_addr[ADDR_W-1:WIN_LOG2]` equals `DRAM_BASE[ADDR_W-1:WIN_LOG2]`. An access outside the window leaves `dram_req` and `bus_wait` low and `dram_ma` at zero.
- R2: In the cycle after acceptance, `dram_req` and `bus_wait` are high and `dram_ma` carries the row, which is the in-window halfword offset `bus_addr[WIN_LOG2-1:1]` shifted right by the column bit count C and truncated to MA_W bits.
- R3: `dram_ma` keeps the row until `col_en` is sampled high during the row phase. From the next cycle on it carries the column, which is the low C bits of the halfword offset with the upper bits at zero.
- R4: The column bit count is C = 8 + `size_sel`: 0 gives 8, 1 gives 9, 2 gives 10 and 3 gives 11 bits. The selector is captured when the transaction is accepted.
- R5: No new access is accepted while a transaction is open. A `dram_rdy` pulse during the row phase is ignored. `dram_req` falls only in the cycle after `dram_rdy` is sampled in the column phase, and it stays low for at least one cycle.
- R6: `dram_burst` equals `bus_burst` while a transaction is open and is low otherwise.
- R7: `bus_wait` is high exactly while a transaction is open, and it drops together with `dram_req`.
- R8: When `dram_rdy` is sampled in the column phase while `bus_burst` is high and fewer than MAX_BEATS beats have completed, `dram_req` stays high. The column then advances by one and wraps within its C-bit field, and no row phase follows.
- R9: A burst ends on the MAX_BEATS-th ready even if `bus_burst` is still high. The default for MAX_BEATS is 8.
- R10: While idle, `dram_ma` is zero and `dram_burst` is low. Reset puts the block in this state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus owner presents an access |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_burst | input | 1 | Burst request of the current bus owner |
| size_sel | input | 2 | DRAM size setting, column bits = 8 + value |
| col_en | input | 1 | Column-enable strobe from the DRAM controller |
| dram_rdy | input | 1 | Beat complete from the DRAM controller |
| dram_req | output | 1 | Transaction request to the DRAM controller |
| dram_burst | output | 1 | Burst indication to the DRAM controller |
| dram_ma | output | MA_W | Multiplexed row/column address bus |
| bus_wait | output | 1 | Stall to the bus master |

## Verification
A phase register stuck in or skipping the row phase shows up one cycle after acceptance, or one cycle after the column strobe, as a wrong value on `dram_ma`. A wrong size capture or column field mask shows up as a wrong column on the first column-phase cycle. A corrupted beat counter or column increment shows up one cycle after a burst ready, either as a request that drops too early or too late, or as a column that does not step or does not wrap. A lost idle return leaves `bus_wait` and `dram_req` high in the cycle after the final ready.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ROW  = 2'd1,
      PH_COL  = 2'd2
   } seq_phase_t;

   localparam int MIN_COL_BITS = 8;
   localparam int NUM_SIZES    = 4;
endpackage

// File: rtl/dram_win_match.sv
module dram_win_match #(
   parameter int          ADDR_W    = 24,
   parameter int          WIN_LOG2  = 21,
   parameter logic [ADDR_W-1:0] DRAM_BASE = 24'h200000
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   localparam int TAG_W = ADDR_W - WIN_LOG2;

   generate
      if (TAG_W < 1) begin : g_bad_win
         $error("dram_win_match: window must be smaller than address space");
      end
   endgenerate

   logic [TAG_W-1:0] tag_ref;
   assign tag_ref = DRAM_BASE[ADDR_W-1:WIN_LOG2];
   assign hit     = (addr[ADDR_W-1:WIN_LOG2] == tag_ref);
endmodule

// File: rtl/dram_addr_split.sv
module dram_addr_split
   import dram_seq_pkg::*;
#(
   parameter int OFF_W = 20,
   parameter int MA_W  = 12
) (
   input  logic [OFF_W-1:0] hw_off,
   input  logic [1:0]       size_sel,
   output logic [MA_W-1:0]  row,
   output logic [MA_W-1:0]  col,
   output logic [MA_W-1:0]  col_mask
);
   localparam int MAX_COL_BITS = MIN_COL_BITS + NUM_SIZES - 1;

   generate
      if (MA_W < MAX_COL_BITS) begin : g_bad_ma
         $error("dram_addr_split: address bus narrower than widest column");
      end
      if (OFF_W < MA_W) begin : g_bad_off
         $error("dram_addr_split: window offset narrower than address bus");
      end
      if (OFF_W - MIN_COL_BITS > MA_W) begin : g_bad_row
         $error("dram_addr_split: row does not fit the address bus");
      end
   endgenerate

   logic [MA_W-1:0] row_c  [NUM_SIZES];
   logic [MA_W-1:0] col_c  [NUM_SIZES];
   logic [MA_W-1:0] mask_c [NUM_SIZES];

   generate
      for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
         localparam int CB = MIN_COL_BITS + s;
         logic [OFF_W-1:0] shifted;
         assign shifted   = hw_off >> CB;
         assign row_c[s]  = shifted[MA_W-1:0];
         assign mask_c[s] = {{(MA_W-CB){1'b0}}, {CB{1'b1}}};
         assign col_c[s]  = hw_off[MA_W-1:0] & mask_c[s];
      end
   endgenerate

   assign row      = row_c[size_sel];
   assign col      = col_c[size_sel];
   assign col_mask = mask_c[size_sel];
endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
   import dram_seq_pkg::*;
#(
   parameter int MA_W      = 12,
   parameter int MAX_BEATS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [MA_W-1:0] row_in,
   input  logic [MA_W-1:0] col_in,
   input  logic [MA_W-1:0] mask_in,
   input  logic            col_en,
   input  logic            dram_rdy,
   input  logic            bus_burst,
   output seq_phase_t      phase,
   output logic            dram_req,
   output logic            dram_burst,
   output logic [MA_W-1:0] dram_ma,
   output logic            bus_wait
);
   localparam int BW = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1;
   localparam logic [BW-1:0] LAST_BEAT = BW'(MAX_BEATS - 1);

   generate
      if (MAX_BEATS < 1) begin : g_bad_beats
         $error("dram_seq_ctrl: MAX_BEATS must be at least 1");
      end
   endgenerate

   seq_phase_t      phase_q;
   logic [MA_W-1:0] row_q, col_q, mask_q;
   logic [BW-1:0]   beat_q;
   logic            more;

   assign more = bus_burst && (beat_q != LAST_BEAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         row_q   <= '0;
         col_q   <= '0;
         mask_q  <= '0;
         beat_q  <= '0;
      end else begin
         case (phase_q)
            PH_IDLE: begin
               if (start) begin
                  phase_q <= PH_ROW;
                  row_q   <= row_in;
                  col_q   <= col_in;
                  mask_q  <= mask_in;
                  beat_q  <= '0;
               end
            end
            PH_ROW: begin
               if (col_en) phase_q <= PH_COL;
            end
            PH_COL: begin
               if (dram_rdy) begin
                  if (more) begin
                     col_q  <= (col_q + 1'b1) & mask_q;
                     beat_q <= beat_q + 1'b1;
                  end else begin
                     phase_q <= PH_IDLE;
                  end
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   logic active;
   assign active     = (phase_q != PH_IDLE);
   assign phase      = phase_q;
   assign dram_req   = active;
   assign bus_wait   = active;
   assign dram_burst = active & bus_burst;

   always_comb begin
      case (phase_q)
         PH_ROW:  dram_ma = row_q;
         PH_COL:  dram_ma = col_q;
         default: dram_ma = '0;
      endcase
   end
endmodule

// File: rtl/dram_addr_seq.sv
module dram_addr_seq
   import dram_seq_pkg::*;
#(
   parameter int                ADDR_W    = 24,
   parameter int                MA_W      = 12,
   parameter int                WIN_LOG2  = 21,
   parameter logic [ADDR_W-1:0] DRAM_BASE = 24'h200000,
   parameter int                MAX_BEATS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_burst,
   input  logic [1:0]        size_sel,
   input  logic              col_en,
   input  logic              dram_rdy,
   output logic              dram_req,
   output logic              dram_burst,
   output logic [MA_W-1:0]   dram_ma,
   output logic              bus_wait
);
   localparam int OFF_W = WIN_LOG2 - 1;

   logic            win_hit;
   logic [MA_W-1:0] split_row, split_col, split_mask;
   seq_phase_t      seq_phase;

   dram_win_match #(
      .ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .DRAM_BASE(DRAM_BASE)
   ) u_win (
      .addr (bus_addr),
      .hit  (win_hit)
   );

   dram_addr_split #(
      .OFF_W(OFF_W), .MA_W(MA_W)
   ) u_split (
      .hw_off   (bus_addr[WIN_LOG2-1:1]),
      .size_sel (size_sel),
      .row      (split_row),
      .col      (split_col),
      .col_mask (split_mask)
   );

   dram_seq_ctrl #(
      .MA_W(MA_W), .MAX_BEATS(MAX_BEATS)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (bus_valid & win_hit),
      .row_in     (split_row),
      .col_in     (split_col),
      .mask_in    (split_mask),
      .col_en     (col_en),
      .dram_rdy   (dram_rdy),
      .bus_burst  (bus_burst),
      .phase      (seq_phase),
      .dram_req   (dram_req),
      .dram_burst (dram_burst),
      .dram_ma    (dram_ma),
      .bus_wait   (bus_wait)
   );
endmodule

// File: rtl/dram_addr_seq_chk.sv
module dram_addr_seq_chk
   import dram_seq_pkg::*;
#(
   parameter int                ADDR_W    = 24,
   parameter int                MA_W      = 12,
   parameter int                WIN_LOG2  = 21,
   parameter logic [ADDR_W-1:0] DRAM_BASE = 24'h200000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [1:0]        size_sel,
   input logic              col_en,
   input logic              dram_rdy,
   input logic              dram_req,
   input logic              dram_burst,
   input logic [MA_W-1:0]   dram_ma,
   input logic              bus_wait,
   input seq_phase_t        phase
);
   logic [MA_W-1:0] step_mask;
   assign step_mask = MA_W'((32'd1 << (MIN_COL_BITS + int'(size_sel))) - 32'd1);

   AST_REQ_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dram_req) |-> ($past(bus_valid) &&
         ($past(bus_addr[ADDR_W-1:WIN_LOG2]) == DRAM_BASE[ADDR_W-1:WIN_LOG2]))); // R1

   AST_COL_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_COL && $past(phase) == PH_ROW) |-> $past(col_en)); // R3

   AST_REQ_DROP_ON_READY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_req) |-> ($past(dram_rdy) && $past(phase) == PH_COL)); // R5

   AST_BURST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_COL && $past(phase) == PH_COL && $past(dram_rdy))
         |-> (dram_ma == (($past(dram_ma) + 1'b1) & step_mask))); // R8

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_req |-> (dram_ma == '0 && !dram_burst && !bus_wait)); // R10
endmodule

bind dram_addr_seq dram_addr_seq_chk #(
   .ADDR_W(ADDR_W), .MA_W(MA_W), .WIN_LOG2(WIN_LOG2), .DRAM_BASE(DRAM_BASE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_valid  (bus_valid),
   .bus_addr   (bus_addr),
   .size_sel   (size_sel),
   .col_en     (col_en),
   .dram_rdy   (dram_rdy),
   .dram_req   (dram_req),
   .dram_burst (dram_burst),
   .dram_ma    (dram_ma),
   .bus_wait   (bus_wait),
   .phase      (seq_phase)
);

// File: tb/dram_addr_seq_tb_top.sv
module dram_addr_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int MAXB       = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic [23:0] bus_addr = '0;
   logic        bus_burst = 1'b0;
   logic [1:0]  size_sel = '0;
   logic        col_en = 1'b0;
   logic        dram_rdy = 1'b0;
   logic        dram_req, dram_burst, bus_wait;
   logic [11:0] dram_ma;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dram_addr_seq dut_i (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
      .bus_burst(bus_burst), .size_sel(size_sel), .col_en(col_en),
      .dram_rdy(dram_rdy), .dram_req(dram_req), .dram_burst(dram_burst),
      .dram_ma(dram_ma), .bus_wait(bus_wait)
   );

   function automatic logic [11:0] mask_of(input logic [1:0] sz);
      return 12'((32'd1 << (8 + int'(sz))) - 32'd1);
   endfunction

   function automatic logic [11:0] row_of(input logic [23:0] a, input logic [1:0] sz);
      logic [19:0] off = a[20:1];
      logic [19:0] sh  = off >> (8 + int'(sz));
      return sh[11:0];
   endfunction

   function automatic logic [11:0] col_of(input logic [23:0] a, input logic [1:0] sz);
      logic [19:0] off = a[20:1];
      return off[11:0] & mask_of(sz);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   endtask

   task automatic txn(input logic [23:0] a, input logic [1:0] sz, input int nb,
                      input int ce_dly, input int rdy_dly, input bit poke);
      bit          inw = (a[23:21] == 3'b001);
      logic [11:0] r = row_of(a, sz);
      logic [11:0] c = col_of(a, sz);
      logic [11:0] m = mask_of(sz);
      @(negedge clk);
      bus_valid = 1'b1; bus_addr = a; size_sel = sz; bus_burst = (nb > 1);
      @(negedge clk);
      bus_valid = 1'b0;
      if (!inw) begin
         chk(dram_req == 1'b0, "R1 req", 32'(dram_req), 0);
         chk(dram_ma == 12'h0, "R1 ma", 32'(dram_ma), 0);
         chk(bus_wait == 1'b0, "R1 wait", 32'(bus_wait), 0);
         bus_burst = 1'b0;
         return;
      end
      chk(dram_req == 1'b1, "R2 req", 32'(dram_req), 1);
      chk(dram_ma == r, "R2/R4 row", 32'(dram_ma), 32'(r));
      chk(bus_wait == 1'b1, "R7 wait", 32'(bus_wait), 1);
      chk(dram_burst == bus_burst, "R6 burst", 32'(dram_burst), 32'(bus_burst));
      for (int i = 0; i < ce_dly; i++) begin
         dram_rdy = (i == 0);
         if (poke) begin bus_valid = 1'b1; bus_addr = a ^ 24'h000F02; end
         @(negedge clk);
         dram_rdy = 1'b0; bus_valid = 1'b0;
         chk(dram_ma == r, "R3/R5 row held", 32'(dram_ma), 32'(r));
         chk(dram_req == 1'b1, "R5 req held", 32'(dram_req), 1);
      end
      col_en = 1'b1;
      @(negedge clk);
      col_en = 1'b0;
      chk(dram_ma == c, "R3/R4 col", 32'(dram_ma), 32'(c));
      for (int b = 0; ; b++) begin
         bit cont;
         bus_burst = (b < nb - 1);
         for (int k = 0; k < rdy_dly; k++) begin
            if (poke) begin bus_valid = 1'b1; bus_addr = a ^ 24'h000204; end
            @(negedge clk);
            bus_valid = 1'b0;
            chk(dram_ma == c, "R3/R5 col held", 32'(dram_ma), 32'(c));
            chk(dram_burst == bus_burst, "R6 burst", 32'(dram_burst), 32'(bus_burst));
            chk(bus_wait == 1'b1, "R7 wait", 32'(bus_wait), 1);
         end
         dram_rdy = 1'b1;
         cont = bus_burst && (b < MAXB - 1);
         @(negedge clk);
         dram_rdy = 1'b0;
         if (cont) begin
            c = (c + 12'd1) & m;
            chk(dram_req == 1'b1, "R8 req", 32'(dram_req), 1);
            chk(dram_ma == c, "R8 next col", 32'(dram_ma), 32'(c));
         end else begin
            if (bus_burst) chk(dram_req == 1'b0, "R9 cap", 32'(dram_req), 0);
            else           chk(dram_req == 1'b0, "R5 drop", 32'(dram_req), 0);
            chk(bus_wait == 1'b0, "R7 wait", 32'(bus_wait), 0);
            chk(dram_ma == 12'h0, "R10 ma", 32'(dram_ma), 0);
            chk(dram_burst == 1'b0, "R6 idle burst", 32'(dram_burst), 0);
            break;
         end
      end
      bus_burst = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'd5150));
      repeat (3) @(negedge clk);
      chk(dram_req == 1'b0, "R10 reset req", 32'(dram_req), 0);
      chk(dram_ma == 12'h0, "R10 reset ma", 32'(dram_ma), 0);
      chk(bus_wait == 1'b0, "R10 reset wait", 32'(bus_wait), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R4: each size setting, single beat
      txn(24'h2ABCDE, 2'd0, 1, 1, 1, 1'b0);
      txn(24'h2ABCDE, 2'd1, 1, 0, 0, 1'b0);
      txn(24'h3FFFFE, 2'd2, 1, 2, 0, 1'b0);
      txn(24'h212346, 2'd3, 1, 1, 2, 1'b0);
      // R1: outside the window
      txn(24'h4ABCDE, 2'd0, 1, 0, 0, 1'b0);
      txn(24'h1FFFFE, 2'd3, 1, 0, 0, 1'b0);
      // R5: ready in row phase and bus pokes while busy
      txn(24'h2F0F0A, 2'd1, 1, 3, 2, 1'b1);
      // R8: short burst and column wrap at the top of the field
      txn(24'h2001FC, 2'd0, 4, 1, 0, 1'b0);
      txn(24'h200FFE, 2'd3, 3, 0, 1, 1'b1);
      // R9: burst held beyond the cap
      txn(24'h234560, 2'd2, 12, 1, 0, 1'b0);
      // back-to-back: request low between transactions (R5)
      txn(24'h2AAAA2, 2'd0, 1, 0, 0, 1'b0);
      chk(dram_req == 1'b0, "R5 gap", 32'(dram_req), 0);
      for (int n = 0; n < 300; n++) begin
         bit          inw = ($urandom % 4) != 0;
         logic [2:0]  top = inw ? 3'b001 : 3'(2 + ($urandom % 6));
         logic [23:0] a   = {top, 21'($urandom)};
         txn(a, 2'($urandom), 1 + int'($urandom % 10), int'($urandom % 4),
             int'($urandom % 4), 1'($urandom));
      end
      finish_run();
   end
endmodule